// File: doc/BRIEF.md
# NAND Flash Cache-Read Device Model

This block is a synthesizable, clock-synchronous model of the flash-device side of a pipelined page read. It is meant to sit in a test environment as the target of a flash controller. The strobes `we_n` and `re_n` are sampled on the system clock. A rising `we_n` with `ce_n` low latches a command byte when `cle` is high, or an address byte when `ale` is high. A falling `re_n` shifts out one byte. Storage is held in three stages: a cell array, a page buffer and a data cache. Serial output always reads the data cache. The page buffer can be refilled from the array in the background while that output runs.

A plain read uses opcode 00h, four address bytes and then 30h. It holds `rb_n` low while the page moves from the array into both stages. The continue opcode 31h moves the page buffer into the cache and then prefetches the next sequential page. The last-page opcode 3Fh does the same move but starts no prefetch. If a prefetch is still running when 31h or 3Fh arrives, busy is stretched until that prefetch ends.

Each page is modelled with 2112 byte positions, columns 0 to 2111. The cell array stores one seed byte per page, and each byte read back is derived from that seed and the column.

States and transitions of the controller:
- `S_IDLE`: after reset. A 00h strobe goes to `S_ADDR`.
- `S_ADDR`: collects address bytes. 00h restarts collection. 30h goes to `S_TR`.
- `S_TR`: array read, lasting T_R cycles. It then goes to `S_READY`.
- `S_READY`: serial output. 00h goes to `S_ADDR`. An accepted 31h or 3Fh goes to `S_WAITF` if a prefetch has more than its final cycle left, and otherwise to `S_XFER`.
- `S_WAITF`: waits for the prefetch, then goes to `S_XFER` on the prefetch's final cycle.
- `S_XFER`: buffer-to-cache move, lasting T_DC cycles. It then goes to `S_READY`.

Top module: `nand_cache_rd`

## Requirements
- R1: After reset `rb_n` is 1, `io_out` is 8'h00 and `err` is 0.
- R2: On a `we_n` rising edge with `ce_n` low, `cle`=1 with `ale`=0 latches a command and `ale`=1 with `cle`=0 latches an address byte. Address bytes are accepted only after 00h, in this order: column low, column high (bits 3:0 used), row low, row high (discarded). The page is row low modulo NUM_PAGES.
- R3: 30h in `S_ADDR` drives `rb_n` low for exactly T_R cycles, starting the cycle after the strobe. Afterwards the cache holds the addressed page and output starts at the given column.
- R4: Each falling `re_n` in `S_READY` updates `io_out` on the next clock with seed ^ col[7:0] ^ {4'h0,col[11:8]}, where seed = (29·page + 7) mod 256. The column then advances by one, saturating at 4095.
- R5: Columns above 2111 read as 8'hA5.
- R6: 31h with no prefetch in flight gives T_DC busy cycles. The cache then holds the former buffer page with column 0, and a T_R-cycle prefetch of page+1 is started.
- R7: 31h while a prefetch runs keeps `rb_n` low for the cycles remaining until that prefetch completes, plus T_DC.
- R8: Serial output keeps working, with `rb_n` high, while a prefetch runs.
- R9: 3Fh moves the buffer into the cache with the same busy rule as 31h. It starts no prefetch and ends the cache read.
- R10: 31h or 3Fh received outside an active cache read (idle, busy, or after 3Fh) causes no busy period and no data change. It sets `err`, which stays set until reset.
- R11: `re_n` falls and unrecognised opcodes have no effect while busy.
- R12: The page after NUM_PAGES-1 is page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command-latch qualifier |
| ale | input | 1 | Address-latch qualifier |
| we_n | input | 1 | Write strobe, rising edge latches |
| re_n | input | 1 | Read strobe, falling edge shifts out a byte |
| io_in | input | 8 | Command and address byte |
| io_out | output | 8 | Serial data byte |
| rb_n | output | 1 | Ready (1) / busy (0) |
| err | output | 1 | Sticky misuse flag |

## Verification
A plain read is started at a column near the end of the page with a nonzero row high byte. This exposes column decoding, address truncation and the fill pattern past column 2111.

Continue commands are issued three ways: straight after the plain read (no prefetch pending), straight after a transfer (prefetch only just started), and after a long pause (prefetch finished). Together these separate the stretched busy time from the fixed one.

A last-page command followed by a stray continue checks that the pipeline ends and that misuse is flagged. A read at the final page checks the wrap to page 0. A behavioural model in the bench compares the outputs on every clock.

// File: rtl/nand_cr_pkg.sv
package nand_cr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_TR,
        S_WAITF,
        S_XFER,
        S_READY
    } ctl_state_t;

    localparam logic [7:0] OP_READ  = 8'h00;
    localparam logic [7:0] OP_CONF  = 8'h30;
    localparam logic [7:0] OP_CNEXT = 8'h31;
    localparam logic [7:0] OP_CLAST = 8'h3F;

    localparam int SEED_MUL = 29;
    localparam int SEED_ADD = 7;

endpackage

// File: rtl/nand_cr_cells.sv
module nand_cr_cells #(
    parameter int NUM_PAGES = 64,
    parameter int PAGE_W    = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] rd_page_i,
    output logic [7:0]        rd_seed_o
);
    import nand_cr_pkg::*;

    logic [7:0] mem [NUM_PAGES];

    // Array content is a per-page seed, filled at reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PAGES; i++) begin
                mem[i] <= 8'((i * SEED_MUL + SEED_ADD) % 256);
            end
        end else begin
            for (int i = 0; i < NUM_PAGES; i++) begin
                mem[i] <= mem[i];
            end
        end
    end

    assign rd_seed_o = mem[rd_page_i];

endmodule

// File: rtl/nand_cr_fetch.sv
module nand_cr_fetch #(
    parameter int NUM_PAGES = 64,
    parameter int PAGE_W    = $clog2(NUM_PAGES),
    parameter int T_R       = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PAGE_W-1:0] start_page_i,
    input  logic              set_i,
    input  logic [PAGE_W-1:0] set_page_i,
    input  logic [7:0]        set_seed_i,
    input  logic [7:0]        arr_seed_i,
    output logic              busy_o,
    output logic              last_o,
    output logic [PAGE_W-1:0] tgt_o,
    output logic [PAGE_W-1:0] pb_page_o,
    output logic [7:0]        pb_seed_o
);
    localparam int CNT_W = $clog2(T_R + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o    <= 1'b0;
            cnt_q     <= '0;
            tgt_o     <= '0;
            pb_page_o <= '0;
            pb_seed_o <= '0;
        end else if (set_i) begin
            busy_o    <= 1'b0;
            cnt_q     <= '0;
            pb_page_o <= set_page_i;
            pb_seed_o <= set_seed_i;
        end else if (start_i) begin
            busy_o <= 1'b1;
            cnt_q  <= CNT_W'(T_R);
            tgt_o  <= start_page_i;
        end else if (busy_o) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                busy_o    <= 1'b0;
                pb_page_o <= tgt_o;
                pb_seed_o <= arr_seed_i;
            end
        end
    end

    assign last_o = busy_o && (cnt_q == CNT_W'(1));

    // R7: a running prefetch always has between 1 and T_R cycles left
    p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt_q >= CNT_W'(1) && cnt_q <= CNT_W'(T_R)));

    // R6: the buffer takes the target page when the prefetch completes
    p_pb_loaded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !set_i && !start_i) |=> (pb_page_o == $past(tgt_o) && !busy_o));

endmodule

// File: rtl/nand_cr_outq.sv
module nand_cr_outq #(
    parameter int         COL_W    = 12,
    parameter int         LAST_COL = 2111,
    parameter logic [7:0] FILL     = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [7:0]       load_seed_i,
    input  logic [COL_W-1:0] load_col_i,
    input  logic             rd_i,
    output logic [7:0]       data_o
);
    logic [7:0]       seed_q;
    logic [COL_W-1:0] col_q;
    logic [7:0]       byte_val;

    always_comb begin
        if (col_q > COL_W'(LAST_COL)) begin
            byte_val = FILL;
        end else begin
            byte_val = seed_q ^ col_q[7:0] ^ {4'h0, col_q[11:8]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seed_q <= '0;
            col_q  <= '0;
            data_o <= '0;
        end else if (load_i) begin
            seed_q <= load_seed_i;
            col_q  <= load_col_i;
        end else if (rd_i) begin
            data_o <= byte_val;
            if (col_q != '1) begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    // R11: the output byte only moves on a read strobe
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i) |=> $stable(data_o));

    // R5: reads beyond the last column give the fill pattern
    p_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !load_i && col_q > COL_W'(LAST_COL)) |=> (data_o == FILL));

endmodule

// File: rtl/nand_cache_rd.sv
module nand_cache_rd #(
    parameter int         NUM_PAGES = 64,
    parameter int         LAST_COL  = 2111,
    parameter int         T_R       = 24,
    parameter int         T_DC      = 5,
    parameter logic [7:0] FILL      = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       rb_n,
    output logic       err
);
    import nand_cr_pkg::*;

    localparam int PAGE_W = $clog2(NUM_PAGES);
    localparam int COL_W  = 12;
    localparam int T_MAX  = (T_R > T_DC) ? T_R : T_DC;
    localparam int CNT_W  = $clog2(T_MAX + 1);

    ctl_state_t        state, nxt;
    logic              we_d, re_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [2:0]        aidx_q;
    logic [COL_W-1:0]  col_a;
    logic [PAGE_W-1:0] page_a;
    logic              cont_q, active_q, err_q;

    logic we_rise, re_fall, cmd_stb, adr_stb, cache_cmd;
    logic enter_addr, tr_done, x_done, take_cache, err_set;

    logic              f_busy, f_last;
    logic [PAGE_W-1:0] f_tgt, pb_page, rd_page;
    logic [7:0]        pb_seed, arr_seed;

    assign we_rise   = we_n && !we_d && !ce_n;
    assign re_fall   = !re_n && re_d;
    assign cmd_stb   = we_rise && cle && !ale;
    assign adr_stb   = we_rise && ale && !cle;
    assign cache_cmd = cmd_stb && (io_in == OP_CNEXT || io_in == OP_CLAST);

    // Next-state and control strobes
    always_comb begin
        nxt        = state;
        enter_addr = 1'b0;
        tr_done    = 1'b0;
        x_done     = 1'b0;
        take_cache = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (cmd_stb && io_in == OP_READ) begin
                    nxt        = S_ADDR;
                    enter_addr = 1'b1;
                end
            end
            S_ADDR: begin
                if (cmd_stb && io_in == OP_READ) begin
                    enter_addr = 1'b1;
                end else if (cmd_stb && io_in == OP_CONF) begin
                    nxt = S_TR;
                end
            end
            S_TR: begin
                if (cnt_q == CNT_W'(1)) begin
                    nxt     = S_READY;
                    tr_done = 1'b1;
                end
            end
            S_READY: begin
                if (cmd_stb && io_in == OP_READ) begin
                    nxt        = S_ADDR;
                    enter_addr = 1'b1;
                end else if (cache_cmd && active_q) begin
                    take_cache = 1'b1;
                    nxt        = (f_busy && !f_last) ? S_WAITF : S_XFER;
                end
            end
            S_WAITF: begin
                if (f_last) begin
                    nxt = S_XFER;
                end
            end
            S_XFER: begin
                if (cnt_q == CNT_W'(1)) begin
                    nxt    = S_READY;
                    x_done = 1'b1;
                end
            end
            default: nxt = S_IDLE;
        endcase
        err_set = cache_cmd && !(state == S_READY && active_q);
    end

    // State register and control datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            we_d     <= 1'b1;
            re_d     <= 1'b1;
            cnt_q    <= '0;
            aidx_q   <= '0;
            col_a    <= '0;
            page_a   <= '0;
            cont_q   <= 1'b0;
            active_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            state <= nxt;
            we_d  <= we_n;
            re_d  <= re_n;

            if (state != S_TR && nxt == S_TR) begin
                cnt_q <= CNT_W'(T_R);
            end else if (state != S_XFER && nxt == S_XFER) begin
                cnt_q <= CNT_W'(T_DC);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end

            if (enter_addr) begin
                aidx_q <= '0;
                col_a  <= '0;
                page_a <= '0;
            end else if (adr_stb && state == S_ADDR && aidx_q < 3'd4) begin
                aidx_q <= aidx_q + 1'b1;
                unique case (aidx_q)
                    3'd0:    col_a[7:0]  <= io_in;
                    3'd1:    col_a[11:8] <= io_in[3:0];
                    3'd2:    page_a      <= io_in[PAGE_W-1:0];
                    default: ;
                endcase
            end

            if (take_cache) begin
                cont_q <= (io_in == OP_CNEXT);
            end

            if (tr_done) begin
                active_q <= 1'b1;
            end else if (enter_addr || (x_done && !cont_q)) begin
                active_q <= 1'b0;
            end

            if (err_set) begin
                err_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        rb_n = !(state == S_TR || state == S_WAITF || state == S_XFER);
        err  = err_q;
    end

    assign rd_page = (state == S_TR) ? page_a : f_tgt;

    nand_cr_cells #(.NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W)) u_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_page_i (rd_page),
        .rd_seed_o (arr_seed)
    );

    nand_cr_fetch #(.NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W), .T_R(T_R)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (x_done && cont_q),
        .start_page_i (PAGE_W'(pb_page + 1'b1)),
        .set_i        (tr_done),
        .set_page_i   (page_a),
        .set_seed_i   (arr_seed),
        .arr_seed_i   (arr_seed),
        .busy_o       (f_busy),
        .last_o       (f_last),
        .tgt_o        (f_tgt),
        .pb_page_o    (pb_page),
        .pb_seed_o    (pb_seed)
    );

    nand_cr_outq #(.COL_W(COL_W), .LAST_COL(LAST_COL), .FILL(FILL)) u_outq (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (tr_done || x_done),
        .load_seed_i (tr_done ? arr_seed : pb_seed),
        .load_col_i  (tr_done ? col_a : '0),
        .rd_i        (re_fall && state == S_READY),
        .data_o      (io_out)
    );

    // R10: the misuse flag never clears without reset
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R7: the wait ends exactly when the prefetch lands
    p_wait_to_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAITF && f_last) |=> (state == S_XFER));

    // R9: no prefetch is ever in flight during a cache move
    p_no_fetch_in_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_XFER) |-> !f_busy);

    // R3: confirming a read drops ready on the next cycle
    p_busy_after_conf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR && cmd_stb && io_in == OP_CONF) |=> !rb_n);

endmodule

// File: tb/nand_cache_rd_bench.sv
module nand_cache_rd_bench;

    localparam int NP   = 64;
    localparam int LAST = 2111;
    localparam int TR   = 24;
    localparam int TDC  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic       rb_n, err;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    nand_cache_rd #(.NUM_PAGES(NP), .LAST_COL(LAST), .T_R(TR), .T_DC(TDC)) u_nand_cache_rd (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .io_in(io_in),
        .io_out(io_out), .rb_n(rb_n), .err(err)
    );

    function automatic int seed_of(int p);
        return (p * 29 + 7) % 256;
    endfunction

    function automatic int byte_of(int p, int c);
        if (c > LAST) return 8'hA5;
        return seed_of(p) ^ (c & 255) ^ ((c >> 8) & 15);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, phases: 0 idle, 1 addr, 2 array read, 3 wait, 4 move, 5 ready
    int m_phase, m_cnt, m_fl, m_ftg, m_pbp, m_cp, m_col, m_cola, m_page, m_ai;
    int m_out, m_err, m_act, m_cont, pwe, pre;

    always @(posedge clk) begin
        int fl;
        bit wr, rf, cmd, adr, cc;
        int b;
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_fl = 0; m_ftg = 0; m_pbp = 0; m_cp = 0;
            m_col = 0; m_cola = 0; m_page = 0; m_ai = 0; m_out = 0; m_err = 0;
            m_act = 0; m_cont = 0; pwe = 1; pre = 1;
        end else begin
            wr  = (we_n == 1'b1) && (pwe == 0) && (ce_n == 1'b0);
            rf  = (re_n == 1'b0) && (pre == 1);
            pwe = we_n; pre = re_n;
            b   = io_in;
            cmd = wr && cle && !ale;
            adr = wr && ale && !cle;
            cc  = cmd && (b == 8'h31 || b == 8'h3F);
            fl  = m_fl;
            if (fl > 0) begin
                if (fl == 1) m_pbp = m_ftg;
                m_fl = fl - 1;
            end
            if (cc && !(m_phase == 5 && m_act == 1)) m_err = 1;
            case (m_phase)
                0: if (cmd && b == 0) begin m_phase = 1; m_ai = 0; m_cola = 0; m_page = 0; end
                1: begin
                    if (cmd && b == 0) begin m_ai = 0; m_cola = 0; m_page = 0; end
                    else if (cmd && b == 8'h30) begin m_phase = 2; m_cnt = TR; end
                    else if (adr && m_ai < 4) begin
                        if (m_ai == 0) m_cola = (m_cola & 32'hF00) | b;
                        if (m_ai == 1) m_cola = (m_cola & 255) | ((b & 15) << 8);
                        if (m_ai == 2) m_page = b % NP;
                        m_ai++;
                    end
                end
                2: if (m_cnt == 1) begin
                        m_phase = 5; m_pbp = m_page; m_cp = m_page; m_col = m_cola;
                        m_act = 1; m_fl = 0;
                    end else m_cnt--;
                3: if (fl == 1) begin m_phase = 4; m_cnt = TDC; end
                4: if (m_cnt == 1) begin
                        m_phase = 5; m_cp = m_pbp; m_col = 0;
                        if (m_cont == 1) begin m_fl = TR; m_ftg = (m_pbp + 1) % NP; end
                        else m_act = 0;
                    end else m_cnt--;
                5: begin
                    if (rf) begin
                        m_out = byte_of(m_cp, m_col);
                        if (m_col < 4095) m_col++;
                    end
                    if (cmd && b == 0) begin
                        m_phase = 1; m_ai = 0; m_cola = 0; m_page = 0; m_act = 0;
                    end else if (cc && m_act == 1) begin
                        m_cont = (b == 8'h31);
                        if (fl > 1) m_phase = 3;
                        else begin m_phase = 4; m_cnt = TDC; end
                    end
                end
                default: ;
            endcase
        end
    end

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            string rt;
            rt = (m_phase == 2) ? "R3 rb_n" : (m_phase == 3) ? "R7 rb_n" :
                 (m_phase == 4) ? "R6 rb_n" : "R11 rb_n";
            check(rt, rb_n, (m_phase >= 2 && m_phase <= 4) ? 0 : 1);
            check("R4 io_out", io_out, m_out);
            check("R10 err", err, m_err);
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic strobe(bit c, bit a, logic [7:0] v);
        cle = c; ale = a; io_in = v; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (rb_n === 1'b0) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_byte(output int v);
        re_n = 1'b0;
        @(negedge clk);
        re_n = 1'b1;
        v = io_out;
        @(negedge clk);
    endtask

    task automatic open_page(int col, int row);
        strobe(1, 0, 8'h00);
        strobe(0, 1, 8'(col & 255));
        strobe(0, 1, 8'(col >> 8));
        strobe(0, 1, 8'(row & 255));
        strobe(0, 1, 8'(row >> 8));
        strobe(1, 0, 8'h30);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n, v, prev;
        do_reset();
        check("R1 rb_n", rb_n, 1);
        check("R1 io_out", io_out, 0);
        check("R1 err", err, 0);

        // R10: continue with no active cache read
        strobe(1, 0, 8'h31);
        repeat (3) @(negedge clk);
        check("R10 err set", err, 1);
        check("R10 no busy", rb_n, 1);
        do_reset();
        check("R1 err cleared", err, 0);

        // R2/R3: row high byte nonzero, page = 0x45 mod 64 = 5
        open_page(2100, 16'h0145);
        wait_ready(n);
        check("R3 tR length", n, TR);
        for (int i = 0; i < 15; i++) begin
            read_byte(v);
            if (2100 + i > LAST) check("R5 fill", v, 8'hA5);
            else check("R2 R4 byte", v, byte_of(5, 2100 + i));
        end

        // R6: no prefetch pending
        strobe(1, 0, 8'h31);
        wait_ready(n);
        check("R6 move length", n, TDC);
        // R7: prefetch just started; issued at once
        strobe(1, 0, 8'h31);
        wait_ready(n);
        check("R7 stretched busy", n, TR - 2 + TDC);
        for (int i = 0; i < 4; i++) begin
            read_byte(v);
            check("R8 byte during prefetch", v, byte_of(6, i));
            check("R8 ready during prefetch", rb_n, 1);
        end
        repeat (40) @(negedge clk);

        // R9: last page, prefetch done
        strobe(1, 0, 8'h3F);
        wait_ready(n);
        check("R9 last-page busy", n, TDC);
        read_byte(v);
        check("R9 page 7 data", v, byte_of(7, 0));
        strobe(1, 0, 8'h31);
        repeat (3) @(negedge clk);
        check("R10 after last page err", err, 1);
        check("R9 no busy after end", rb_n, 1);
        read_byte(v);
        check("R10 cache unchanged", v, byte_of(7, 1));

        // R11 and R12: read during busy, then wrap from the final page
        prev = io_out;
        open_page(0, NP - 1);
        read_byte(v);
        check("R11 read ignored while busy", v, prev);
        wait_ready(n);
        strobe(1, 0, 8'h90);
        strobe(1, 0, 8'h31);
        wait_ready(n);
        strobe(1, 0, 8'h31);
        wait_ready(n);
        read_byte(v);
        check("R12 wrap to page 0", v, byte_of(0, 0));

        repeat (5) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule